// File: doc/BRIEF.md
# SPI Transaction Pause Controller

This block sits between the pins of a serial peripheral slave and its protocol engine. It lets the bus master pause a transaction that is under way without deselecting the slave. Three pins are watched: the active-low select, the serial clock and an active-low pause pin. From them the block derives a pause state. While paused, the receive shifter is frozen, the serial data output is released to high impedance, and clock and data-in activity is ignored. Both entering and leaving the pause take effect only while the serial clock is low. A pause-pin edge that arrives while the clock is high waits for the next low phase.

All pins are brought into the system clock domain through a configurable synchronizer chain and are then evaluated on that clock. A bit counter and shift register assemble incoming words MSB first and keep their contents across a pause, so the word resumes from the same bit. Deselecting the slave while it is paused issues a one-cycle transaction-reset pulse. A pause that has been requested but has not yet taken effect is simply dropped when the slave is deselected.

Top module: `spi_hold_ctrl`

## Requirements
- R1: After reset, freeze, so_oe, txn_reset and rx_valid are all 0.
- R2: With spi_cs_n low and spi_hold_n high, so_oe is 1 and freeze is 0.
- R3: When spi_hold_n falls while spi_sck is low and spi_cs_n is low, freeze becomes 1 and so_oe becomes 0.
- R4: When spi_hold_n falls while spi_sck is high, freeze stays 0 until spi_sck goes low, and then becomes 1.
- R5: When spi_hold_n rises while spi_sck is low, freeze returns to 0 and so_oe to 1.
- R6: When spi_hold_n rises while spi_sck is high, freeze stays 1 until spi_sck goes low.
- R7: While frozen, spi_sck rising edges and spi_si are ignored; the bit count and partial word are kept, so the word finished after the pause equals the bits sent outside it.
- R8: Raising spi_cs_n while frozen gives exactly one txn_reset pulse of one clock cycle, clears freeze and discards the partial word; the next full word after reselection is received intact.
- R9: Raising spi_cs_n while a pause is requested but not yet in effect (spi_hold_n low, spi_sck high) cancels it: no txn_reset pulse, and freeze stays 0 when spi_sck then goes low.
- R10: After a transaction reset, selecting again with spi_hold_n still low leaves the block paused (freeze 1, so_oe 0) until spi_hold_n goes high.
- R11: A pause can only begin while selected: spi_hold_n low with spi_cs_n high never sets freeze.
- R12: Words are shifted in MSB first on spi_sck rising edges; after WORD_BITS rising edges rx_word holds the word and rx_valid pulses for one cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_cs_n | input | 1 | Slave select, active low |
| spi_sck | input | 1 | Serial clock pin |
| spi_hold_n | input | 1 | Pause request, active low |
| spi_si | input | 1 | Serial data in |
| freeze | output | 1 | Pause in effect; protocol engine must stand still |
| so_oe | output | 1 | Output enable for the serial data out driver |
| txn_reset | output | 1 | One-cycle pulse: transaction aborted during a pause |
| rx_word | output | WORD_BITS | Last word received |
| rx_valid | output | 1 | One-cycle pulse when rx_word is updated |

## Verification
The hardest situations to reach are the deferred edges: a pause-pin change that lands in a clock-high phase and must wait, and a deselect that arrives while a request is still waiting. The stimulus reaches them by holding spi_sck high for several system clocks, changing spi_hold_n inside that window, and checking freeze before and after the clock falls. A further case deselects in the same window. Words sent with pauses in the middle are pushed to a scoreboard queue. Intact words after the pause then show that the bit position was preserved and that the clock toggles made during the pause were discarded.

// File: rtl/spi_hold_pkg.sv
package spi_hold_pkg;

    typedef enum logic [2:0] {
        HS_IDLE,
        HS_RUN,
        HS_ENTER_WAIT,
        HS_PAUSED,
        HS_EXIT_WAIT
    } hold_state_e;

    typedef struct packed {
        logic sel_n;
        logic clk_lvl;
        logic pause_n;
        logic din;
    } pin_bus_t;

    localparam pin_bus_t PIN_IDLE = '{sel_n: 1'b1, clk_lvl: 1'b0, pause_n: 1'b1, din: 1'b0};

    function automatic logic is_frozen(hold_state_e s);
        return (s == HS_PAUSED) || (s == HS_EXIT_WAIT);
    endfunction

    function automatic logic drives_out(hold_state_e s);
        return (s == HS_RUN) || (s == HS_ENTER_WAIT);
    endfunction

endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync
    import spi_hold_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  pin_bus_t raw,
    output pin_bus_t synced,
    output logic     clk_rise
);

    logic clk_prev;

    generate
        if (STAGES == 0) begin : g_pass
            assign synced = raw;
        end else begin : g_chain
            pin_bus_t stg [STAGES];
            always_ff @(posedge clk) begin
                if (rst) begin
                    for (int i = 0; i < STAGES; i++) stg[i] <= PIN_IDLE;
                end else begin
                    stg[0] <= raw;
                    for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
                end
            end
            assign synced = stg[STAGES-1];
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) clk_prev <= 1'b0;
        else     clk_prev <= synced.clk_lvl;
    end

    assign clk_rise = synced.clk_lvl & ~clk_prev;

endmodule

// File: rtl/spi_hold_fsm.sv
module spi_hold_fsm
    import spi_hold_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  pin_bus_t pins,
    output logic     freeze,
    output logic     so_oe,
    output logic     txn_reset
);

    hold_state_e state_q, state_d;
    logic        txn_reset_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            HS_IDLE: begin
                if (!pins.sel_n) state_d = HS_RUN;
            end
            HS_RUN: begin
                if (pins.sel_n)             state_d = HS_IDLE;
                else if (!pins.pause_n)     state_d = pins.clk_lvl ? HS_ENTER_WAIT : HS_PAUSED;
            end
            HS_ENTER_WAIT: begin
                if (pins.sel_n)             state_d = HS_IDLE;
                else if (pins.pause_n)      state_d = HS_RUN;
                else if (!pins.clk_lvl)     state_d = HS_PAUSED;
            end
            HS_PAUSED: begin
                if (pins.sel_n)             state_d = HS_IDLE;
                else if (pins.pause_n)      state_d = pins.clk_lvl ? HS_EXIT_WAIT : HS_RUN;
            end
            HS_EXIT_WAIT: begin
                if (pins.sel_n)             state_d = HS_IDLE;
                else if (!pins.pause_n)     state_d = HS_PAUSED;
                else if (!pins.clk_lvl)     state_d = HS_RUN;
            end
            default: state_d = HS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q     <= HS_IDLE;
            txn_reset_q <= 1'b0;
        end else begin
            state_q     <= state_d;
            txn_reset_q <= is_frozen(state_q) && pins.sel_n;
        end
    end

    assign freeze    = is_frozen(state_q);
    assign so_oe     = drives_out(state_q);
    assign txn_reset = txn_reset_q;

    AST_PAUSE_ONLY_SELECTED: assert property (@(posedge clk) disable iff (rst)
        $rose(freeze) |-> !$past(pins.sel_n)); // R11

    AST_ENTER_ON_LOW_CLK: assert property (@(posedge clk) disable iff (rst)
        $rose(freeze) |-> !$past(pins.clk_lvl)); // R4

    AST_EXIT_ON_LOW_CLK: assert property (@(posedge clk) disable iff (rst)
        ($fell(freeze) && !txn_reset) |-> !$past(pins.clk_lvl)); // R6

    AST_DESEL_UNFREEZES: assert property (@(posedge clk) disable iff (rst)
        (freeze && pins.sel_n) |=> (!freeze && txn_reset)); // R8

    AST_TXN_RESET_SINGLE: assert property (@(posedge clk) disable iff (rst)
        txn_reset |=> !txn_reset); // R8

endmodule

// File: rtl/spi_rx_shift.sv
module spi_rx_shift #(
    parameter int WORD_BITS = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 sck_rise,
    input  logic                 din,
    input  logic                 sel_n,
    input  logic                 freeze,
    input  logic                 txn_reset,
    output logic [WORD_BITS-1:0] rx_word,
    output logic                 rx_valid
);

    localparam int CNT_W = (WORD_BITS > 1) ? $clog2(WORD_BITS) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_BITS - 1);

    logic [CNT_W-1:0]     bit_cnt;
    logic [WORD_BITS-1:0] shreg;
    logic [WORD_BITS-1:0] shnext;
    logic                 clr;

    assign clr    = sel_n | txn_reset;
    assign shnext = {shreg[WORD_BITS-2:0], din};

    always_ff @(posedge clk) begin
        if (rst) begin
            bit_cnt  <= '0;
            shreg    <= '0;
            rx_word  <= '0;
            rx_valid <= 1'b0;
        end else begin
            rx_valid <= 1'b0;
            if (clr) begin
                bit_cnt <= '0;
            end else if (sck_rise && !freeze) begin
                shreg <= shnext;
                if (bit_cnt == LAST) begin
                    bit_cnt  <= '0;
                    rx_word  <= shnext;
                    rx_valid <= 1'b1;
                end else begin
                    bit_cnt <= bit_cnt + 1'b1;
                end
            end
        end
    end

    AST_COUNT_KEPT_FROZEN: assert property (@(posedge clk) disable iff (rst)
        (freeze && !clr) |=> ($stable(bit_cnt) && $stable(shreg))); // R7

    AST_NO_WORD_FROZEN: assert property (@(posedge clk) disable iff (rst)
        freeze |=> !rx_valid); // R7

endmodule

// File: rtl/spi_hold_ctrl.sv
module spi_hold_ctrl
    import spi_hold_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int WORD_BITS   = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 spi_cs_n,
    input  logic                 spi_sck,
    input  logic                 spi_hold_n,
    input  logic                 spi_si,
    output logic                 freeze,
    output logic                 so_oe,
    output logic                 txn_reset,
    output logic [WORD_BITS-1:0] rx_word,
    output logic                 rx_valid
);

    pin_bus_t raw_pins;
    pin_bus_t sync_pins;
    logic     sck_rise;

    assign raw_pins = '{sel_n: spi_cs_n, clk_lvl: spi_sck, pause_n: spi_hold_n, din: spi_si};

    spi_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .raw      (raw_pins),
        .synced   (sync_pins),
        .clk_rise (sck_rise)
    );

    spi_hold_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .pins      (sync_pins),
        .freeze    (freeze),
        .so_oe     (so_oe),
        .txn_reset (txn_reset)
    );

    spi_rx_shift #(.WORD_BITS(WORD_BITS)) u_shift (
        .clk       (clk),
        .rst       (rst),
        .sck_rise  (sck_rise),
        .din       (sync_pins.din),
        .sel_n     (sync_pins.sel_n),
        .freeze    (freeze),
        .txn_reset (txn_reset),
        .rx_word   (rx_word),
        .rx_valid  (rx_valid)
    );

    AST_OUT_OFF_WHEN_FROZEN: assert property (@(posedge clk) disable iff (rst)
        freeze |-> !so_oe); // R3

endmodule

// File: tb/spi_hold_ctrl_tb_top.sv
module spi_hold_ctrl_tb_top;

    localparam int W = 8;
    localparam int SETTLE = 6;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         cs_n = 1'b1, sck = 1'b0, hold_n = 1'b1, si = 1'b0;
    logic         freeze, so_oe, txn_reset, rx_valid;
    logic [W-1:0] rx_word;

    int errors = 0;
    int checks = 0;
    int txn_pulses = 0;
    logic [W-1:0] exp_q [$];

    always #10 clk = ~clk;

    spi_hold_ctrl #(.SYNC_STAGES(2), .WORD_BITS(W)) dut_i (
        .clk(clk), .rst(rst), .spi_cs_n(cs_n), .spi_sck(sck), .spi_hold_n(hold_n),
        .spi_si(si), .freeze(freeze), .so_oe(so_oe), .txn_reset(txn_reset),
        .rx_word(rx_word), .rx_valid(rx_valid)
    );

    task automatic check(input logic ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic settle();
        repeat (SETTLE) @(negedge clk);
    endtask

    // monitor: scoreboard pop on each received word, txn pulse counter
    always @(negedge clk) begin
        if (!rst && txn_reset) txn_pulses++;
        if (!rst && rx_valid) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R12 unexpected word", int'(rx_word), 0);
            end else begin
                logic [W-1:0] e;
                e = exp_q.pop_front();
                check(rx_word == e, "R12/R7 word", int'(rx_word), int'(e));
            end
        end
    end

    // pause inside clock-low phase, with junk clocking while paused
    task automatic pause_low();
        hold_n = 1'b0; settle();
        check(freeze == 1'b1, "R3 freeze", freeze, 1);
        check(so_oe == 1'b0, "R3 so_oe", so_oe, 0);
        for (int k = 0; k < 3; k++) begin
            si = ~si; sck = 1'b1; settle(); sck = 1'b0; settle();
        end
        hold_n = 1'b1; settle();
        check(freeze == 1'b0, "R5 freeze", freeze, 0);
        check(so_oe == 1'b1, "R5 so_oe", so_oe, 1);
    endtask

    // pause requested and released while clock is high
    task automatic pause_high();
        hold_n = 1'b0; settle();
        check(freeze == 1'b0, "R4 deferred entry", freeze, 0);
        sck = 1'b0; settle();
        check(freeze == 1'b1, "R4 entry at low", freeze, 1);
        si = ~si; sck = 1'b1; settle();
        hold_n = 1'b1; settle();
        check(freeze == 1'b1, "R6 deferred exit", freeze, 1);
        sck = 1'b0; settle();
        check(freeze == 1'b0, "R6 exit at low", freeze, 0);
    endtask

    // mode: 0 none, 1 pause in low phase, 2 pause in high phase
    task automatic send_word(input logic [W-1:0] b, input int at_bit, input int mode);
        exp_q.push_back(b);
        for (int i = W - 1; i >= 0; i--) begin
            sck = 1'b0; si = b[i]; settle();
            if (i == at_bit && mode == 1) begin
                pause_low();
                si = b[i]; settle();
            end
            sck = 1'b1; settle();
            if (i == at_bit && mode == 2) pause_high();
        end
        sck = 1'b0; settle();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(freeze == 0, "R1 freeze", freeze, 0);
        check(so_oe == 0, "R1 so_oe", so_oe, 0);
        check(txn_reset == 0, "R1 txn_reset", txn_reset, 0);
        check(rx_valid == 0, "R1 rx_valid", rx_valid, 0);

        cs_n = 1'b0; settle();
        check(so_oe == 1 && freeze == 0, "R2 selected", so_oe, 1);

        send_word(8'hA5, -1, 0);
        send_word(8'h3C, 5, 1);
        send_word(8'h96, 2, 2);
        send_word(8'h01, 0, 1);
        check(exp_q.size() == 0, "R12 words drained", exp_q.size(), 0);

        cs_n = 1'b1; settle();
        hold_n = 1'b0; settle();
        check(freeze == 0, "R11 no pause unselected", freeze, 0);
        hold_n = 1'b1; settle();

        // R8: abort while paused, then R10 reselect with pause still low
        cs_n = 1'b0; settle();
        for (int i = 0; i < 3; i++) begin
            sck = 1'b0; si = 1'b1; settle(); sck = 1'b1; settle();
        end
        sck = 1'b0; settle();
        hold_n = 1'b0; settle();
        check(freeze == 1, "R8 paused before abort", freeze, 1);
        cs_n = 1'b1; settle();
        check(txn_pulses == 1, "R8 one txn pulse", txn_pulses, 1);
        check(freeze == 0, "R8 freeze cleared", freeze, 0);
        cs_n = 1'b0; settle();
        check(freeze == 1, "R10 still paused", freeze, 1);
        check(so_oe == 0, "R10 output off", so_oe, 0);
        hold_n = 1'b1; settle();
        check(freeze == 0 && so_oe == 1, "R10 resumed", freeze, 0);
        send_word(8'h5A, -1, 0);

        // R9: pending request cancelled by deselect
        sck = 1'b1; settle();
        hold_n = 1'b0; settle();
        check(freeze == 0, "R9 pending", freeze, 0);
        cs_n = 1'b1; settle();
        sck = 1'b0; settle();
        check(freeze == 0, "R9 cancelled", freeze, 0);
        check(txn_pulses == 1, "R9 no txn pulse", txn_pulses, 1);
        hold_n = 1'b1; settle();
        cs_n = 1'b0; settle();
        send_word(8'hC3, -1, 0);
        cs_n = 1'b1; settle();
        check(exp_q.size() == 0, "R8 all words seen", exp_q.size(), 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule